// File: doc/BRIEF.md
# Indirect-Source DMA Channel

This block is one DMA channel that moves a single data unit per peripheral request. In indirect mode the source register does not point at the data. It points at a 32-bit pointer. For each request the channel runs three memory accesses in turn. It reads a longword pointer from the source address, then reads one data unit of the configured size from the address held in that pointer, then writes that unit to the destination address. In direct mode the pointer fetch is skipped and the data is read straight from the source address.

Software programs four registers through a small register port: source address, destination address, transfer count and a control word. After each transfer the channel steps its addresses, decrements its count and releases the bus. It raises an end flag, with an optional interrupt, when the count reaches zero. The memory master port carries a request, write strobe, size, address and data. It waits on a ready signal and uses little-endian byte lanes on a 32-bit data bus.

Top module: `indirect_dma_channel`

## Requirements
- R1: After reset all four registers read zero, and memReq, dack and irq are low.
- R2: In indirect mode (control bit 7 = 1) each transfer is a longword read (memSize = 2) at the source address, then a read of the configured size at the address returned by that read, then a write of the same size to the destination address.
- R3: Source mode (control bits 4:3; 0 fixed, 1 increment, 2 decrement) steps the source address after each transfer. The step is 4 in indirect mode and the transfer size in bytes in direct mode.
- R4: Destination mode (control bits 6:5, same coding) steps the destination address by the transfer size in bytes (byte 1, word 2, longword 4) or holds it.
- R5: Size (control bits 2:1; 0 byte, 1 word, 2 longword) selects the lane. A byte uses lane address[1:0] and a word uses lane address[1]×2. Read data is taken from the lane of the read address, and write data is placed on the lane of the destination address with all other bits zero.
- R6: The count register (select 2) decrements by one per completed transfer. A request that arrives while the count is zero gets no acknowledge and causes no memory access.
- R7: Each request grants exactly one transfer. dack is high for one cycle, the cycle in which the first read is presented, and memReq is low after the write completes until the next request is granted.
- R8: The end flag (control bit 9) is set when the count goes from 1 to 0. A control write with bit 9 = 0 clears it, but a set in the same cycle takes priority. irq equals the flag AND the interrupt enable (control bit 8).
- R9: With enable (control bit 0) clear, requests are ignored. Clearing enable during a transfer lets that transfer finish.
- R10: In direct mode (control bit 7 = 0) there is no pointer read. The data read uses the source address.
- R11: While memReq is high and memReady is low, the address, size, write strobe and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Read data of the selected register |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | One-cycle request acknowledge |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memSize | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| memAddr | output | ADDR_W | Access byte address |
| memWdata | output | 32 | Write data, lane aligned |
| memRdata | input | 32 | Read data |
| memReady | input | 1 | Access completes on a cycle where memReq and memReady are both high |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
Two things can land in the same cycle: the update step of the final transfer setting the end flag, and a software control write that clears it. The bench watches the port for the write handshake of the last transfer. It then times a control write with bit 9 = 0 so that it lands exactly in the update cycle. The flag must read 1 afterwards. A later write, issued on its own, must clear it. The sweep over size, source mode, destination mode, indirect bit and memory wait states exercises the other addressing paths.

// File: rtl/ind_dma_pkg.sv
package ind_dma_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [1:0] AM_FIXED = 2'd0;
  localparam logic [1:0] AM_INC   = 2'd1;
  localparam logic [1:0] AM_DEC   = 2'd2;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTL  = 2'd3;

  localparam int CTL_EN    = 0;
  localparam int CTL_SIZE  = 1;
  localparam int CTL_SMODE = 3;
  localparam int CTL_DMODE = 5;
  localparam int CTL_IND   = 7;
  localparam int CTL_IRQEN = 8;
  localparam int CTL_END   = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_DATA, ST_WRITE, ST_UPDATE
  } chState_e;

  typedef enum logic [1:0] {
    SEL_SRC, SEL_PTR, SEL_DST
  } addrSel_e;

  typedef struct packed {
    logic     loadPtr;
    logic     loadData;
    logic     update;
    addrSel_e addrSel;
  } dpStrobe_t;

endpackage

// File: rtl/ind_dma_datapath.sv
module ind_dma_datapath
  import ind_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  dpStrobe_t         stb,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              chEnable,
  output logic              indirect,
  output logic [1:0]        xferSize,
  output logic              cntZero,
  output logic              irq
);

  localparam int CTL_W = CTL_END + 1;

  logic [ADDR_W-1:0] srcAddr, dstAddr, ptrQ, dataAddr;
  logic [CNT_W-1:0]  count;
  logic [31:0]       dataQ;
  logic              enableQ, indQ, irqEnQ, endFlagQ;
  logic [1:0]        sizeQ, sModeQ, dModeQ;
  logic [2:0]        sizeBytes, srcStep;
  logic [CTL_W-1:0]  ctlWord;
  logic              wrSrc, wrDst, wrCnt, wrCtl;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic [2:0] step);
    case (mode)
      AM_INC:  return a + ADDR_W'(step);
      AM_DEC:  return a - ADDR_W'(step);
      default: return a;
    endcase
  endfunction

  function automatic logic [4:0] laneShift(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {lo, 3'b000};
      SZ_WORD: return {lo[1], 4'b0000};
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] sizeMask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  assign wrSrc = cfgWrEn && (cfgSel == REG_SRC);
  assign wrDst = cfgWrEn && (cfgSel == REG_DST);
  assign wrCnt = cfgWrEn && (cfgSel == REG_CNT);
  assign wrCtl = cfgWrEn && (cfgSel == REG_CTL);

  assign sizeBytes = (sizeQ == SZ_BYTE) ? 3'd1 : (sizeQ == SZ_WORD) ? 3'd2 : 3'd4;
  assign srcStep   = indQ ? 3'd4 : sizeBytes;
  assign dataAddr  = indQ ? ptrQ : srcAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      count    <= '0;
      enableQ  <= 1'b0;
      sizeQ    <= SZ_BYTE;
      sModeQ   <= AM_FIXED;
      dModeQ   <= AM_FIXED;
      indQ     <= 1'b0;
      irqEnQ   <= 1'b0;
      endFlagQ <= 1'b0;
      ptrQ     <= '0;
      dataQ    <= '0;
    end else begin
      if (wrSrc)           srcAddr <= cfgWrData[ADDR_W-1:0];
      else if (stb.update) srcAddr <= stepAddr(srcAddr, sModeQ, srcStep);

      if (wrDst)           dstAddr <= cfgWrData[ADDR_W-1:0];
      else if (stb.update) dstAddr <= stepAddr(dstAddr, dModeQ, sizeBytes);

      if (wrCnt)           count <= cfgWrData[CNT_W-1:0];
      else if (stb.update) count <= count - 1'b1;

      if (wrCtl) begin
        enableQ <= cfgWrData[CTL_EN];
        sizeQ   <= cfgWrData[CTL_SIZE +: 2];
        sModeQ  <= cfgWrData[CTL_SMODE +: 2];
        dModeQ  <= cfgWrData[CTL_DMODE +: 2];
        indQ    <= cfgWrData[CTL_IND];
        irqEnQ  <= cfgWrData[CTL_IRQEN];
      end

      if (stb.update && count == CNT_W'(1)) endFlagQ <= 1'b1;
      else if (wrCtl && !cfgWrData[CTL_END]) endFlagQ <= 1'b0;

      if (stb.loadPtr)  ptrQ  <= memRdata[ADDR_W-1:0];
      if (stb.loadData) dataQ <= (memRdata >> laneShift(dataAddr[1:0], sizeQ)) & sizeMask(sizeQ);
    end
  end

  always_comb begin
    case (stb.addrSel)
      SEL_PTR: memAddr = ptrQ;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = srcAddr;
    endcase
  end

  assign memWdata = (dataQ & sizeMask(sizeQ)) << laneShift(dstAddr[1:0], sizeQ);

  assign ctlWord = {endFlagQ, irqEnQ, indQ, dModeQ, sModeQ, sizeQ, enableQ};

  always_comb begin
    case (cfgSel)
      REG_SRC: cfgRdData = 32'(srcAddr);
      REG_DST: cfgRdData = 32'(dstAddr);
      REG_CNT: cfgRdData = 32'(count);
      default: cfgRdData = 32'(ctlWord);
    endcase
  end

  assign chEnable = enableQ;
  assign indirect = indQ;
  assign xferSize = sizeQ;
  assign cntZero  = (count == '0);
  assign irq      = endFlagQ && irqEnQ;

  AST_SRC_STEP_PTR: assert property (@(posedge clk) disable iff (!rstN)
    stb.update && indQ && sModeQ == AM_INC && !wrSrc |=> srcAddr == $past(srcAddr) + ADDR_W'(4)); // R3
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    stb.update && !wrCnt |=> count == $past(count) - 1'b1); // R6
  AST_END_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.update && count == CNT_W'(1) |=> endFlagQ); // R8

endmodule

// File: rtl/ind_dma_ctrl.sv
module ind_dma_ctrl
  import ind_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dreq,
  input  logic      memReady,
  input  logic      chEnable,
  input  logic      indirect,
  input  logic [1:0] xferSize,
  input  logic      cntZero,
  output dpStrobe_t stb,
  output logic      dack,
  output logic      memReq,
  output logic      memWe,
  output logic [1:0] memSize
);

  chState_e stateQ, stateNext;
  logic     startXfer;

  assign startXfer = (stateQ == ST_IDLE) && chEnable && !cntZero && dreq;

  always_comb begin
    stateNext   = stateQ;
    stb         = '0;
    stb.addrSel = SEL_SRC;
    memReq      = 1'b0;
    memWe       = 1'b0;
    memSize     = xferSize;
    case (stateQ)
      ST_IDLE: if (startXfer) stateNext = indirect ? ST_PTR : ST_DATA;
      ST_PTR: begin
        memReq  = 1'b1;
        memSize = SZ_LONG;
        if (memReady) begin
          stb.loadPtr = 1'b1;
          stateNext   = ST_DATA;
        end
      end
      ST_DATA: begin
        memReq      = 1'b1;
        stb.addrSel = indirect ? SEL_PTR : SEL_SRC;
        if (memReady) begin
          stb.loadData = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        stb.addrSel = SEL_DST;
        if (memReady) stateNext = ST_UPDATE;
      end
      ST_UPDATE: begin
        stb.update = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      dack   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      dack   <= startXfer;
    end
  end

  AST_DACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dack |=> !dack); // R7
  AST_DACK_FIRST_READ: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> memReq && !memWe); // R7
  AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && memWe == $past(memWe) && memSize == $past(memSize)); // R11

endmodule

// File: rtl/indirect_dma_channel.sv
module indirect_dma_channel
  import ind_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              dreq,
  output logic              dack,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  output logic              irq
);

  dpStrobe_t stb;
  logic      chEnable, indirect, cntZero;
  logic [1:0] xferSize;

  ind_dma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .memReady(memReady),
    .chEnable(chEnable), .indirect(indirect), .xferSize(xferSize), .cntZero(cntZero),
    .stb(stb), .dack(dack), .memReq(memReq), .memWe(memWe), .memSize(memSize)
  );

  ind_dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .stb(stb), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .chEnable(chEnable), .indirect(indirect), .xferSize(xferSize),
    .cntZero(cntZero), .irq(irq)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady && !cfgWrEn |=> $stable(memAddr) && $stable(memWdata)); // R11

endmodule

// File: tb/test_indirect_dma_channel.sv
module test_indirect_dma_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        dreq = 1'b0;
  logic        dack, memReq, memWe, memReady, irq;
  logic [1:0]  memSize;
  logic [31:0] memAddr, memWdata, memRdata;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  indirect_dma_channel i_indirect_dma_channel (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .dreq(dreq), .dack(dack), .memReq(memReq), .memWe(memWe),
    .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .irq(irq)
  );

  // memory model and access log
  logic [31:0] mem [0:255];
  int          waitSet = 0;
  int          waitCnt;
  logic [31:0] logAddr [0:7];
  logic [31:0] logData [0:7];
  logic [1:0]  logSize [0:7];
  logic        logWe   [0:7];
  int          logN = 0;
  int          dackCnt = 0;

  assign memReady = memReq && (waitCnt == waitSet);
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (!rstN || !memReq || memReady) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
    if (dack) dackCnt = dackCnt + 1;
    if (memReq && memReady) begin
      if (logN < 8) begin
        logAddr[logN] = memAddr;
        logSize[logN] = memSize;
        logWe[logN]   = memWe;
        logData[logN] = memWe ? memWdata : memRdata;
      end
      logN = logN + 1;
      if (memWe) begin
        for (int l = 0; l < 4; l++) begin
          if (memSize == 2'd2 ||
              (memSize == 2'd1 && (l >> 1) == int'(memAddr[1])) ||
              (memSize == 2'd0 && l == int'(memAddr[1:0])))
            mem[memAddr[9:2]][8*l +: 8] = memWdata[8*l +: 8];
        end
      end
    end
  end

  function automatic logic [31:0] pat(input int w);
    logic [7:0] b;
    b = 8'(w);
    return {b ^ 8'h5A, b + 8'h11, b ^ 8'hC3, b + 8'h77};
  endfunction

  function automatic int szBytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic int laneSh(input logic [31:0] a, input int sz);
    if (sz == 0) return 8 * int'(a[1:0]);
    if (sz == 1) return 16 * int'(a[1]);
    return 0;
  endfunction

  function automatic logic [31:0] szMask(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic checkEq(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, output logic [31:0] v);
    cfgSel = sel;
    #1;
    v = cfgRdData;
  endtask

  // one request; waits for nAcc accesses (0 = expect none)
  task automatic doTransfer(input int nAcc);
    logN = 0; dackCnt = 0; dreq = 1'b1;
    if (nAcc == 0) begin
      repeat (20) @(negedge clk);
      dreq = 1'b0;
      return;
    end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (dack) break;
    end
    dreq = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (logN >= nAcc) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ctlVal(input int en, input int sz, input int sm,
                                         input int dm, input int ind, input int ie);
    return 32'(en | (sz << 1) | (sm << 3) | (dm << 5) | (ind << 7) | (ie << 8));
  endfunction

  task automatic runConfig(input int sz, input int sm, input int dm, input int ind, input int ws);
    logic [31:0] src0, dst0, srcK, dstK, ptrK, expD, v;
    int sStep, nX;
    nX = 3;
    waitSet = ws;
    for (int w = 0; w < 256; w++) mem[w] = pat(w);
    for (int j = 0; j < 4; j++)
      mem[64 + j] = 32'h200 + 32'(16 * j) +
                    ((sz == 0) ? 32'(j & 3) : (sz == 1) ? 32'((j & 1) * 2) : 32'd0);
    for (int w = 192; w < 200; w++) mem[w] = '0;
    sStep = ind ? 4 : szBytes(sz);
    if (ind) src0 = (sm == 1) ? 32'h100 : (sm == 2) ? 32'h108 : 32'h104;
    else     src0 = (sm == 1) ? 32'h240 : (sm == 2) ? 32'h248 : 32'h244;
    dst0 = (dm == 2) ? 32'h310 : 32'h300;
    cfgWrite(2'd0, src0);
    cfgWrite(2'd1, dst0);
    cfgWrite(2'd2, 32'(nX));
    cfgWrite(2'd3, ctlVal(1, sz, sm, dm, ind, ind));
    for (int k = 0; k < nX; k++) begin
      srcK = (sm == 1) ? src0 + 32'(k * sStep) : (sm == 2) ? src0 - 32'(k * sStep) : src0;
      dstK = (dm == 1) ? dst0 + 32'(k * szBytes(sz)) :
             (dm == 2) ? dst0 - 32'(k * szBytes(sz)) : dst0;
      if (ind) begin
        int j;
        j = int'(srcK - 32'h100) / 4;
        ptrK = 32'h200 + 32'(16 * j) +
               ((sz == 0) ? 32'(j & 3) : (sz == 1) ? 32'((j & 1) * 2) : 32'd0);
      end else ptrK = srcK;
      expD = (pat(int'(ptrK >> 2)) >> laneSh(ptrK, sz)) & szMask(sz);
      doTransfer(ind ? 3 : 2);
      checkEq("R7", "accesses per request", 32'(logN), ind ? 32'd3 : 32'd2);
      checkEq("R7", "dack cycles", 32'(dackCnt), 32'd1);
      checkEq("R11", "memReq idle after transfer", 32'(memReq), 32'd0);
      if (ind) begin
        checkEq("R2", "pointer read address", logAddr[0], srcK);
        checkEq("R2", "pointer read is longword read", {29'd0, logWe[0], logSize[0]}, 32'd2);
        checkEq("R2", "data read uses pointer", logAddr[1], ptrK);
        checkEq("R2", "data read size", {29'd0, logWe[1], logSize[1]}, 32'(sz));
      end else begin
        checkEq("R10", "direct data read address", logAddr[0], srcK);
        checkEq("R10", "direct data read size", {29'd0, logWe[0], logSize[0]}, 32'(sz));
      end
      checkEq("R4", "write address", logAddr[ind ? 2 : 1], dstK);
      checkEq("R4", "write is write of size", {29'd0, logWe[ind ? 2 : 1], logSize[ind ? 2 : 1]},
              32'(4 + sz));
      checkEq("R5", "write data lane", logData[ind ? 2 : 1], expD << laneSh(dstK, sz));
      checkEq("R5", "memory after write",
              (mem[dstK[9:2]] >> laneSh(dstK, sz)) & szMask(sz), expD);
      cfgRead(2'd0, v);
      checkEq("R3", "source after step",
              v, (sm == 1) ? srcK + 32'(sStep) : (sm == 2) ? srcK - 32'(sStep) : srcK);
      cfgRead(2'd2, v);
      checkEq("R6", "count after transfer", v, 32'(nX - k - 1));
    end
    cfgRead(2'd3, v);
    checkEq("R8", "end flag", 32'(v[9]), 32'd1);
    checkEq("R8", "irq follows enable", 32'(irq), 32'(ind));
    doTransfer(0);
    checkEq("R6", "request at zero count acks", 32'(dackCnt), 32'd0);
    checkEq("R6", "request at zero count accesses", 32'(logN), 32'd0);
    cfgWrite(2'd3, ctlVal(1, sz, sm, dm, ind, ind));
    cfgRead(2'd3, v);
    checkEq("R8", "end flag cleared", 32'(v[9]), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    for (int w = 0; w < 256; w++) mem[w] = pat(w);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "memReq after reset", 32'(memReq), 32'd0);
    checkEq("R1", "dack after reset", 32'(dack), 32'd0);
    checkEq("R1", "irq after reset", 32'(irq), 32'd0);
    for (int s = 0; s < 4; s++) begin
      cfgRead(2'(s), v);
      checkEq("R1", "register after reset", v, 32'd0);
    end

    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int ind = 0; ind < 2; ind++)
            runConfig(sz, sm, dm, ind, (sz + sm + dm + ind) % 3);

    // R9: disabled channel ignores requests
    waitSet = 1;
    cfgWrite(2'd0, 32'h100);
    cfgWrite(2'd1, 32'h300);
    cfgWrite(2'd2, 32'd2);
    cfgWrite(2'd3, ctlVal(0, 0, 1, 1, 1, 0));
    doTransfer(0);
    checkEq("R9", "disabled: no dack", 32'(dackCnt), 32'd0);
    checkEq("R9", "disabled: no access", 32'(logN), 32'd0);
    // R9: clear enable during a transfer
    cfgWrite(2'd3, ctlVal(1, 0, 1, 1, 1, 0));
    logN = 0; dackCnt = 0; dreq = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (dack) break;
    end
    dreq = 1'b0;
    cfgWrite(2'd3, ctlVal(0, 0, 1, 1, 1, 0));
    for (int i = 0; i < 100; i++) begin
      if (logN >= 3) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    checkEq("R9", "transfer completes after disable", 32'(logN), 32'd3);
    cfgRead(2'd2, v);
    checkEq("R9", "count after disabled-mid transfer", v, 32'd1);
    doTransfer(0);
    checkEq("R9", "no further transfer", 32'(logN), 32'd0);

    // R8: flag set and clearing write in the same cycle
    cfgWrite(2'd2, 32'd1);
    cfgWrite(2'd3, ctlVal(1, 0, 1, 1, 1, 1));
    logN = 0; dreq = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dack) dreq = 1'b0;
      if (memReq && memWe && memReady) break;
    end
    dreq = 1'b0;
    @(negedge clk);
    cfgWrite(2'd3, ctlVal(1, 0, 1, 1, 1, 1));
    cfgRead(2'd3, v);
    checkEq("R8", "set wins over clear", 32'(v[9]), 32'd1);
    checkEq("R8", "irq with set flag", 32'(irq), 32'd1);
    cfgWrite(2'd3, ctlVal(1, 0, 1, 1, 1, 1));
    cfgRead(2'd3, v);
    checkEq("R8", "later clear", 32'(v[9]), 32'd0);
    checkEq("R8", "irq after clear", 32'(irq), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule